// File: doc/BRIEF.md
# Ring Frame Node

This block joins one module of a larger system to a one-way ring that carries commands and results. Each frame is six bytes wide. It arrives from the upstream neighbour over a single-rail, four-phase request/acknowledge link. The node may rewrite the frame, then passes it to the downstream neighbour over a second link of the same kind. The node has its own clock. The incoming request on the upstream link and the incoming acknowledge on the downstream link each pass through a two-stage synchroniser before any logic uses them. The data of a frame is bundled with its request: it is stable from before the request rises until the acknowledge is seen.

A frame whose address field names this node is decoded. If the local module is free, the command code and its 32-bit argument are issued as a single-cycle strobe. In both cases the status byte is rewritten from the module's current state. An empty frame is one with address zero. When the node holds a result, it fills the first empty frame that passes, so that the frame carries the result to the controller. Results enter over a valid/ready port. The producer holds res_valid high and res_data stable until it sees res_ready high at a clock edge; the word moves on that edge. The node holds one result and keeps res_ready low until that result has left in a frame. The receive side and the send side each have their own frame register. A new frame can therefore be taken in while the previous one still waits for its downstream acknowledge.

Top module: `ring_node`

## Requirements
- R1: After reset, up_ack and dn_req are low, cmd_valid is low and res_ready is high.
- R2: A frame is 48 bits with byte 0 in bits 47:40. Byte 0 holds the 3-bit address in its upper bits and the 5-bit command in its lower bits. Bytes 1 to 4 (bits 39:8) form the argument, with byte 1 as its most significant byte. Byte 5 (bits 7:0) is the status: bit 0 received, bit 1 executed, bit 2 busy, bit 3 error. Bits 7:4 of the status are written as zero whenever the node rewrites it.
- R3: A frame whose address is neither zero nor the node's address leaves the node unchanged.
- R4: A frame addressed to the node while mod_busy is low produces exactly one cycle of cmd_valid, with cmd_code and cmd_arg taken from the frame. Its status leaves with received set and busy clear.
- R5: A frame addressed to the node while mod_busy is high produces no cmd_valid. Its status leaves with busy set and received clear.
- R6: In a rewritten status, the executed bit is set when a mod_done pulse has arrived since the last accepted command, and the error bit copies mod_error.
- R7: An empty frame that passes while a result is held leaves as {controller address 7, node address zero-extended to 5 bits}, then the result word, then status 8'h02. The result is released and res_ready returns high.
- R8: An empty frame that passes while no result is held leaves unchanged.
- R9: While a result is held, res_ready stays low, and a second offered result is taken only after the first has been sent.
- R10: On the upstream link, up_ack rises only after up_req is high and falls only after up_req has fallen.
- R11: On the downstream link, dn_req stays high with dn_frame stable until dn_ack is seen, and no new request starts before dn_ack has fallen.
- R12: While one frame waits for its downstream acknowledge, the node takes one more frame from upstream, and both leave in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Node clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Request from upstream neighbour |
| up_frame | input | 48 | Frame from upstream, bundled with up_req |
| up_ack | output | 1 | Acknowledge to upstream neighbour |
| dn_req | output | 1 | Request to downstream neighbour |
| dn_frame | output | 48 | Frame to downstream, bundled with dn_req |
| dn_ack | input | 1 | Acknowledge from downstream neighbour |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 5 | Command code of the accepted command |
| cmd_arg | output | 32 | Argument of the accepted command |
| mod_busy | input | 1 | Local module cannot take a command |
| mod_done | input | 1 | Pulse: local module finished its command |
| mod_error | input | 1 | Local module error state |
| res_valid | input | 1 | Result word offered |
| res_ready | output | 1 | Node can take a result word |
| res_data | input | 32 | Result word |

## Verification
The bench rewrites status under each combination of busy, error and completion history. A node that sampled the busy state at the wrong moment would issue commands it had refused, and one that never cleared its completion memory would report executed for every later command. It holds back the downstream acknowledge and sends two frames, so a design with only one frame register would stall the upstream link. It offers a second result while the first is still held. A design that overwrote the held word would send the second value in the first empty frame, and one that filled empty frames with nothing held would corrupt frames that should pass unchanged.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  localparam int BYTE_W      = 8;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_W     = BYTE_W * FRAME_BYTES;
  localparam int ARG_W       = BYTE_W * (FRAME_BYTES - 2);

  // status byte bit positions (decoded by the controller)
  localparam int ST_RECV = 0;
  localparam int ST_EXEC = 1;
  localparam int ST_BUSY = 2;
  localparam int ST_ERR  = 3;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef enum logic [1:0] {TX_IDLE, TX_REQ, TX_DROP} tx_state_e;
endpackage

// File: rtl/ring_sync2.sv
module ring_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ring_node_rx.sv
module ring_node_rx import ring_node_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   up_req,
  output logic   up_ack,
  input  frame_t proc_frame,
  input  logic   take,
  output logic   cap,
  output logic   buf_full,
  output frame_t buf_frame
);
  logic req_s;

  ring_sync2 #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst_n(rst_n), .d(up_req), .q(req_s)
  );

  assign cap = !up_ack && req_s && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_ack    <= 1'b0;
      buf_full  <= 1'b0;
      buf_frame <= '0;
    end else begin
      if (cap) begin
        up_ack    <= 1'b1;
        buf_full  <= 1'b1;
        buf_frame <= proc_frame;
      end else begin
        if (up_ack && !req_s) up_ack <= 1'b0;
        if (take) buf_full <= 1'b0;
      end
    end
  end

  assert_ack_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack && req_s |=> up_ack);
  assert_ack_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ack && !req_s |=> !up_ack);
endmodule

// File: rtl/ring_node_proc.sv
module ring_node_proc import ring_node_pkg::*; #(
  parameter int ADDR_W    = 3,
  parameter int NODE_ADDR = 2,
  parameter int CTRL_ADDR = 7
) (
  input  frame_t                    f_in,
  input  logic                      mod_busy,
  input  logic                      done_flag,
  input  logic                      mod_error,
  input  logic                      res_full,
  input  logic [ARG_W-1:0]          res_word,
  output frame_t                    f_out,
  output logic                      issue,
  output logic                      fill,
  output logic [BYTE_W-ADDR_W-1:0]  code,
  output logic [ARG_W-1:0]          arg
);
  localparam int CMD_W = BYTE_W - ADDR_W;

  logic [ADDR_W-1:0] addr;
  logic              hit, empty;
  logic [BYTE_W-1:0] status;

  assign addr  = f_in[FRAME_W-1 -: ADDR_W];
  assign code  = f_in[FRAME_W-ADDR_W-1 -: CMD_W];
  assign arg   = f_in[FRAME_W-BYTE_W-1 -: ARG_W];
  assign hit   = (addr == ADDR_W'(NODE_ADDR));
  assign empty = (addr == '0);

  always_comb begin
    status          = '0;
    status[ST_RECV] = !mod_busy;
    status[ST_EXEC] = done_flag;
    status[ST_BUSY] = mod_busy;
    status[ST_ERR]  = mod_error;
  end

  always_comb begin
    f_out = f_in;
    issue = 1'b0;
    fill  = 1'b0;
    if (hit) begin
      issue              = !mod_busy;
      f_out[BYTE_W-1:0]  = status;
    end else if (empty && res_full) begin
      fill  = 1'b1;
      f_out = {ADDR_W'(CTRL_ADDR), CMD_W'(NODE_ADDR), res_word, BYTE_W'(1 << ST_EXEC)};
    end
  end
endmodule

// File: rtl/ring_node_tx.sv
module ring_node_tx import ring_node_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   buf_full,
  input  frame_t buf_frame,
  output logic   take,
  output logic   dn_req,
  output frame_t dn_frame,
  input  logic   dn_ack
);
  tx_state_e state;
  logic      ack_s;

  ring_sync2 #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(dn_ack), .q(ack_s)
  );

  assign take = (state == TX_IDLE) && buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      dn_req   <= 1'b0;
      dn_frame <= '0;
    end else begin
      unique case (state)
        TX_IDLE: if (take) begin
          dn_frame <= buf_frame;
          dn_req   <= 1'b1;
          state    <= TX_REQ;
        end
        TX_REQ: if (ack_s) begin
          dn_req <= 1'b0;
          state  <= TX_DROP;
        end
        TX_DROP: if (!ack_s) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_req_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !ack_s |=> dn_req);
  assert_frame_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && $past(dn_req) |-> $stable(dn_frame));
  assert_no_req_before_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_req && ack_s |=> !dn_req);
endmodule

// File: rtl/ring_node.sv
module ring_node import ring_node_pkg::*; #(
  parameter int ADDR_W      = 3,
  parameter int NODE_ADDR   = 2,
  parameter int CTRL_ADDR   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      up_req,
  input  logic [FRAME_W-1:0]        up_frame,
  output logic                      up_ack,
  output logic                      dn_req,
  output logic [FRAME_W-1:0]        dn_frame,
  input  logic                      dn_ack,
  output logic                      cmd_valid,
  output logic [BYTE_W-ADDR_W-1:0]  cmd_code,
  output logic [ARG_W-1:0]          cmd_arg,
  input  logic                      mod_busy,
  input  logic                      mod_done,
  input  logic                      mod_error,
  input  logic                      res_valid,
  output logic                      res_ready,
  input  logic [ARG_W-1:0]          res_data
);
  localparam int CMD_W = BYTE_W - ADDR_W;

  frame_t             proc_frame, buf_frame;
  logic               cap, take, buf_full, issue, fill;
  logic               done_flag, res_full;
  logic [ARG_W-1:0]   res_word;
  logic [CMD_W-1:0]   code_w;
  logic [ARG_W-1:0]   arg_w;

  ring_node_proc #(.ADDR_W(ADDR_W), .NODE_ADDR(NODE_ADDR), .CTRL_ADDR(CTRL_ADDR)) u_proc (
    .f_in(up_frame), .mod_busy(mod_busy), .done_flag(done_flag), .mod_error(mod_error),
    .res_full(res_full), .res_word(res_word), .f_out(proc_frame), .issue(issue),
    .fill(fill), .code(code_w), .arg(arg_w)
  );

  ring_node_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_ack(up_ack), .proc_frame(proc_frame),
    .take(take), .cap(cap), .buf_full(buf_full), .buf_frame(buf_frame)
  );

  ring_node_tx #(.SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .buf_frame(buf_frame), .take(take),
    .dn_req(dn_req), .dn_frame(dn_frame), .dn_ack(dn_ack)
  );

  assign res_ready = !res_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      cmd_arg   <= '0;
      done_flag <= 1'b0;
      res_full  <= 1'b0;
      res_word  <= '0;
    end else begin
      cmd_valid <= cap && issue;
      if (cap && issue) begin
        cmd_code  <= code_w;
        cmd_arg   <= arg_w;
        done_flag <= 1'b0;
      end else if (mod_done) begin
        done_flag <= 1'b1;
      end
      if (cap && fill) begin
        res_full <= 1'b0;
      end else if (res_valid && !res_full) begin
        res_full <= 1'b1;
        res_word <= res_data;
      end
    end
  end

  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(mod_busy));
  assert_result_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready && !(cap && fill) |=> !res_ready);
endmodule

// File: tb/ring_node_test.sv
module ring_node_test;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_req = 1'b0;
  logic [47:0] up_frame = '0;
  logic        up_ack;
  logic        dn_req;
  logic [47:0] dn_frame;
  logic        dn_ack = 1'b0;
  logic        cmd_valid;
  logic [4:0]  cmd_code;
  logic [31:0] cmd_arg;
  logic        mod_busy = 1'b0, mod_done = 1'b0, mod_error = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [31:0] res_data = '0;

  int tests = 0, fails = 0, cmd_cnt = 0, cycles = 0;
  logic [4:0]  seen_code;
  logic [31:0] seen_arg;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_node uut (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .up_frame(up_frame), .up_ack(up_ack),
    .dn_req(dn_req), .dn_frame(dn_frame), .dn_ack(dn_ack), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .mod_busy(mod_busy), .mod_done(mod_done),
    .mod_error(mod_error), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst_n && cmd_valid) begin
      cmd_cnt++;
      seen_code = cmd_code;
      seen_arg  = cmd_arg;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_sig(ref logic s, input logic lvl, input string req);
    int n = 0;
    while (s !== lvl && n < TMO) begin @(negedge clk); n++; end
    if (n >= TMO) chk(req, {63'd0, s}, {63'd0, lvl});
  endtask

  task automatic send_frame(input logic [47:0] f);
    @(negedge clk);
    chk("R10 ack low before req", {63'd0, up_ack}, 64'd0);
    up_frame = f;
    @(negedge clk);
    up_req = 1'b1;
    wait_sig(up_ack, 1'b1, "R10 ack rise");
    repeat (3) @(negedge clk);
    chk("R10 ack held while req high", {63'd0, up_ack}, 64'd1);
    up_req = 1'b0;
    wait_sig(up_ack, 1'b0, "R10 ack fall");
  endtask

  task automatic get_frame(output logic [47:0] f);
    wait_sig(dn_req, 1'b1, "R11 req rise");
    f = dn_frame;
    repeat (4) @(negedge clk);
    chk("R11 req held without ack", {63'd0, dn_req}, 64'd1);
    chk("R11 frame stable", {16'd0, dn_frame}, {16'd0, f});
    dn_ack = 1'b1;
    wait_sig(dn_req, 1'b0, "R11 req fall");
    repeat (4) @(negedge clk);
    chk("R11 no req while ack high", {63'd0, dn_req}, 64'd0);
    dn_ack = 1'b0;
  endtask

  task automatic pass_through(input logic [47:0] f, output logic [47:0] o);
    send_frame(f);
    get_frame(o);
  endtask

  task automatic t_reset;
    chk("R1 up_ack", {63'd0, up_ack}, 64'd0);
    chk("R1 dn_req", {63'd0, dn_req}, 64'd0);
    chk("R1 cmd_valid", {63'd0, cmd_valid}, 64'd0);
    chk("R1 res_ready", {63'd0, res_ready}, 64'd1);
  endtask

  task automatic t_forward;
    logic [47:0] o;
    int c0 = cmd_cnt;
    pass_through({3'd5, 5'd9, 32'hCAFE0001, 8'h5A}, o);
    chk("R3 other address unchanged", {16'd0, o}, {16'd0, 3'd5, 5'd9, 32'hCAFE0001, 8'h5A});
    pass_through({3'd7, 5'd1, 32'h00000002, 8'h01}, o);
    chk("R3 controller address unchanged", {16'd0, o}, {16'd0, 3'd7, 5'd1, 32'h00000002, 8'h01});
    chk("R3 no command issued", cmd_cnt, c0);
  endtask

  task automatic t_issue;
    logic [47:0] o;
    int c0 = cmd_cnt;
    pass_through({3'd2, 5'h13, 32'hDEADBEEF, 8'hF0}, o);
    chk("R4 one strobe", cmd_cnt, c0 + 1);
    chk("R4 code", {59'd0, seen_code}, 64'h13);
    chk("R2 argument byte order", {32'd0, seen_arg}, 64'hDEADBEEF);
    chk("R2 R4 frame with status rewritten", {16'd0, o}, {16'd0, 3'd2, 5'h13, 32'hDEADBEEF, 8'h01});
  endtask

  task automatic t_busy;
    logic [47:0] o;
    int c0 = cmd_cnt;
    mod_busy = 1'b1;
    pass_through({3'd2, 5'h04, 32'h11112222, 8'h00}, o);
    mod_busy = 1'b0;
    chk("R5 no strobe when busy", cmd_cnt, c0);
    chk("R5 busy status", {56'd0, o[7:0]}, 64'h04);
  endtask

  task automatic t_exec_err;
    logic [47:0] o;
    @(negedge clk); mod_done = 1'b1;
    @(negedge clk); mod_done = 1'b0;
    mod_error = 1'b1;
    pass_through({3'd2, 5'h05, 32'h0, 8'h00}, o);
    mod_error = 1'b0;
    chk("R6 executed and error flags", {56'd0, o[7:0]}, 64'h0B);
    pass_through({3'd2, 5'h06, 32'h0, 8'h00}, o);
    chk("R6 executed cleared by accept", {56'd0, o[7:0]}, 64'h01);
  endtask

  task automatic t_empty_idle;
    logic [47:0] o;
    pass_through({3'd0, 5'd0, 32'h0, 8'h00}, o);
    chk("R8 empty frame unchanged", {16'd0, o}, 64'd0);
  endtask

  task automatic t_result;
    logic [47:0] o;
    @(negedge clk); res_data = 32'h12345678; res_valid = 1'b1;
    @(negedge clk);
    chk("R9 ready drops after take", {63'd0, res_ready}, 64'd0);
    res_data = 32'hAAAA5555;
    repeat (5) @(negedge clk);
    chk("R9 ready held low", {63'd0, res_ready}, 64'd0);
    pass_through({3'd0, 5'd0, 32'h0, 8'h00}, o);
    chk("R7 filled frame", {16'd0, o}, {16'd0, 3'd7, 5'd2, 32'h12345678, 8'h02});
    @(negedge clk);
    res_valid = 1'b0;
    pass_through({3'd0, 5'd0, 32'h0, 8'h00}, o);
    chk("R9 second result after first", {16'd0, o}, {16'd0, 3'd7, 5'd2, 32'hAAAA5555, 8'h02});
    chk("R7 ready returns", {63'd0, res_ready}, 64'd1);
  endtask

  task automatic t_overlap;
    logic [47:0] o1, o2;
    send_frame({3'd4, 5'd1, 32'h01010101, 8'h11});
    send_frame({3'd6, 5'd2, 32'h02020202, 8'h22});
    chk("R12 second frame taken while first waits", {63'd0, dn_req}, 64'd1);
    get_frame(o1);
    get_frame(o2);
    chk("R12 first out", {16'd0, o1}, {16'd0, 3'd4, 5'd1, 32'h01010101, 8'h11});
    chk("R12 second out", {16'd0, o2}, {16'd0, 3'd6, 5'd2, 32'h02020202, 8'h22});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_forward();
    t_issue();
    t_busy();
    t_exec_err();
    t_empty_idle();
    t_result();
    t_overlap();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule